// File: doc/BRIEF.md
# I2C Status Flag Register

This block keeps three sticky status flags for an I2C controller. The flags are a continuous-transfer flag, a flag that records a match on the alternate (second) slave address, and an arbitration-lost flag. The shifting engine sends one-cycle event strobes: transmit buffer emptied, receive buffer filled, start condition seen, address frame complete (with the received byte), bus bit mismatch, and interrupt flag cleared. The engine also drives level mode inputs that give master or slave, transmit or receive, bus format or another serial format, and whether the alternate address is enabled.

Software reads the status byte through a small register port. Software can clear a flag only by writing 0 to it after a read has returned that flag as 1. Hardware events also clear some flags. When a set event and a clear condition arrive in the same cycle, the set event wins, so no event is lost.

Top module: `i2c_stat_flags`

## Requirements
- R1: After a synchronous reset, all three flags and `cpu_rdata` are 0.
- R2: A `cpu_rd` cycle loads `cpu_rdata` on the next edge with the status byte as it stood before that edge. Bit 5 holds continuous-transfer, bit 4 holds alternate-address-hit, bit 3 holds arbitration-lost, and all other bits are 0. When `cpu_rd` is low, `cpu_rdata` keeps its value.
- R3: The alternate-address-hit flag sets on `ev_addr_done` only when all of these hold: slave mode, receive mode, bus format, `alt_addr_off` = 0, and `rx_byte[7:1]` equal to `alt_addr`.
- R4: The alternate-address-hit flag clears on `ev_start`. It is also held at 0 for as long as `mode_master` is 1.
- R5: The continuous-transfer flag sets on `ev_tx_empty` or `ev_rx_full`. In slave mode with bus format, it sets only if the alternate-address-hit flag is already 1.
- R6: The continuous-transfer flag clears on `ev_irq_clr`.
- R7: The arbitration-lost flag sets on `ev_bit_mismatch` in master mode. In slave mode, `ev_bit_mismatch` is ignored.
- R8: A write with a flag's bit at 0 clears that flag only if an earlier read, made while the flag was 1, has armed the flag. A write of 0 without such a read leaves the flag set.
- R9: A write with a flag's bit at 1 never changes that flag.
- R10: If a set event and any clear condition hit the same flag in one cycle, the flag is 1 afterwards.
- R11: Clearing a flag by any means, including a clear that a simultaneous set overrides, disarms it. After that, software must read the flag as 1 again before a write of 0 can clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_master | input | 1 | 1 = master mode, 0 = slave |
| mode_xmit | input | 1 | 1 = transmit, 0 = receive |
| mode_i2c_fmt | input | 1 | 1 = I2C bus format, 0 = other serial format |
| alt_addr_off | input | 1 | 1 disables alternate address recognition |
| alt_addr | input | ADDR_W | Alternate slave address |
| rx_byte | input | REG_W | First byte received after a start |
| ev_tx_empty | input | 1 | Transmit buffer became empty |
| ev_rx_full | input | 1 | Receive buffer became full |
| ev_start | input | 1 | Start condition detected |
| ev_addr_done | input | 1 | Address frame complete, `rx_byte` valid |
| ev_bit_mismatch | input | 1 | Sampled bus level differed from driven bit |
| ev_irq_clr | input | 1 | Interrupt flag was cleared |
| cpu_rd | input | 1 | Status read strobe |
| cpu_wr | input | 1 | Status write strobe |
| cpu_wdata | input | REG_W | Write data |
| cpu_rdata | output | REG_W | Registered read data |
| flag_xfer_cont | output | 1 | Continuous-transfer flag |
| flag_addr2_hit | output | 1 | Alternate-address-hit flag |
| flag_arb_lost | output | 1 | Arbitration-lost flag |

## Verification
The hardest cases to reach are those that depend on history as well as on current inputs. One is a write of 0 that lands after a hardware clear has silently disarmed an earlier read, with the flag set again since. Another is a continuous-transfer event in slave bus mode that must see the alternate-address flag from a previous address frame. Directed sequences build each of these histories step by step: read, clear, re-set, write. A long random phase then drives dense overlapping strobes, with about half the address frames matching, so that set/clear collisions occur many times. A behavioural model checks the result on every cycle.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  // Bit positions in the status byte (software-visible layout)
  localparam int unsigned ARB_BIT   = 3;
  localparam int unsigned ADDR2_BIT = 4;
  localparam int unsigned XFER_BIT  = 5;

  // Flag slot indices; slot i lives at bit ARB_BIT + i
  localparam int unsigned FL_ARB   = 0;
  localparam int unsigned FL_ADDR2 = 1;
  localparam int unsigned FL_XFER  = 2;
  localparam int unsigned NFLAG    = 3;

  function automatic int unsigned flag_bit(input int unsigned idx);
    return ARB_BIT + idx;
  endfunction
endpackage

// File: rtl/stat_flag_cell.sv
// One sticky flag with a read-armed software clear.
module stat_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic hw_clr,
  input  logic rd_en,
  input  logic wr_en,
  input  logic wr_bit,
  output logic flag
);
  logic flag_q, armed_q;
  logic sw_clr, any_clr, flag_d, armed_d;

  always_comb begin
    sw_clr  = wr_en & ~wr_bit & armed_q;
    any_clr = hw_clr | sw_clr;
    flag_d  = set_ev | (flag_q & ~any_clr);
    if (any_clr || !flag_d)
      armed_d = 1'b0;
    else
      armed_d = armed_q | (rd_en & flag_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/alt_addr_detect.sv
// Qualifies an address frame against the alternate slave address.
module alt_addr_detect #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              addr_done,
  input  logic              master,
  input  logic              xmit,
  input  logic              bus_fmt,
  input  logic              alt_off,
  input  logic [ADDR_W-1:0] frame_addr,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              hit
);
  logic mode_ok, addr_eq;

  always_comb begin
    mode_ok = ~master & ~xmit & bus_fmt & ~alt_off;
    addr_eq = (frame_addr == own_addr);
    hit     = addr_done & mode_ok & addr_eq;
  end
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_master,
  input  logic              mode_xmit,
  input  logic              mode_i2c_fmt,
  input  logic              alt_addr_off,
  input  logic [ADDR_W-1:0] alt_addr,
  input  logic [REG_W-1:0]  rx_byte,
  input  logic              ev_tx_empty,
  input  logic              ev_rx_full,
  input  logic              ev_start,
  input  logic              ev_addr_done,
  input  logic              ev_bit_mismatch,
  input  logic              ev_irq_clr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  output logic              flag_xfer_cont,
  output logic              flag_addr2_hit,
  output logic              flag_arb_lost
);
  localparam int unsigned PAD_W = REG_W - ADDR_W;

  logic [NFLAG-1:0] set_v, hclr_v, flag_v;
  logic             alt_hit, slave_bus;
  logic [REG_W-1:0] status, rdata_q;
  logic             unused_bits;

  alt_addr_detect #(.ADDR_W(ADDR_W)) u_detect (
    .addr_done  (ev_addr_done),
    .master     (mode_master),
    .xmit       (mode_xmit),
    .bus_fmt    (mode_i2c_fmt),
    .alt_off    (alt_addr_off),
    .frame_addr (rx_byte[REG_W-1 -: ADDR_W]),
    .own_addr   (alt_addr),
    .hit        (alt_hit)
  );

  assign slave_bus = ~mode_master & mode_i2c_fmt;

  assign set_v[FL_ARB]    = mode_master & ev_bit_mismatch;
  assign hclr_v[FL_ARB]   = 1'b0;
  assign set_v[FL_ADDR2]  = alt_hit;
  assign hclr_v[FL_ADDR2] = ev_start | mode_master;
  assign set_v[FL_XFER]   = (ev_tx_empty | ev_rx_full) & (~slave_bus | flag_v[FL_ADDR2]);
  assign hclr_v[FL_XFER]  = ev_irq_clr;

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    stat_flag_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .set_ev (set_v[gi]),
      .hw_clr (hclr_v[gi]),
      .rd_en  (cpu_rd),
      .wr_en  (cpu_wr),
      .wr_bit (cpu_wdata[flag_bit(gi)]),
      .flag   (flag_v[gi])
    );
  end

  always_comb begin
    status = '0;
    for (int i = 0; i < NFLAG; i++)
      status[flag_bit(i)] = flag_v[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (cpu_rd)
      rdata_q <= status;
  end

  assign cpu_rdata      = rdata_q;
  assign flag_xfer_cont = flag_v[FL_XFER];
  assign flag_addr2_hit = flag_v[FL_ADDR2];
  assign flag_arb_lost  = flag_v[FL_ARB];

  assign unused_bits = ^{cpu_wdata[REG_W-1:XFER_BIT+1], cpu_wdata[ARB_BIT-1:0],
                         rx_byte[PAD_W-1:0]};
endmodule

// File: rtl/i2c_stat_flags_chk.sv
module i2c_stat_flags_chk (
  input logic clk,
  input logic rst,
  input logic mode_master,
  input logic mode_i2c_fmt,
  input logic ev_tx_empty,
  input logic ev_rx_full,
  input logic ev_start,
  input logic ev_addr_done,
  input logic ev_bit_mismatch,
  input logic ev_irq_clr,
  input logic cpu_rd,
  input logic cpu_wr,
  input logic wd_arb,
  input logic flag_xfer_cont,
  input logic flag_addr2_hit,
  input logic flag_arb_lost,
  input logic rd_xfer,
  input logic rd_addr2,
  input logic rd_arb
);
  assert_rd_snapshot_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_rd |=> (rd_xfer == $past(flag_xfer_cont) && rd_addr2 == $past(flag_addr2_hit)
                && rd_arb == $past(flag_arb_lost)));

  assert_addr2_master_clr_R4: assert property (@(posedge clk) disable iff (rst)
    mode_master |=> !flag_addr2_hit);

  assert_addr2_start_clr_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_start && !ev_addr_done) |=> !flag_addr2_hit);

  assert_xfer_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (!mode_master && mode_i2c_fmt && !flag_addr2_hit && !flag_xfer_cont) |=> !flag_xfer_cont);

  assert_xfer_irq_clr_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_irq_clr && !ev_tx_empty && !ev_rx_full) |=> !flag_xfer_cont);

  assert_arb_set_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_master && ev_bit_mismatch) |=> flag_arb_lost);

  assert_arb_slave_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (!mode_master && !flag_arb_lost) |=> !flag_arb_lost);

  assert_arb_wr0_unarmed_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag_arb_lost) && cpu_wr && !wd_arb) |=> flag_arb_lost);

  assert_arb_wr1_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_arb_lost && cpu_wr && wd_arb) |=> flag_arb_lost);
endmodule

bind i2c_stat_flags i2c_stat_flags_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .mode_master     (mode_master),
  .mode_i2c_fmt    (mode_i2c_fmt),
  .ev_tx_empty     (ev_tx_empty),
  .ev_rx_full      (ev_rx_full),
  .ev_start        (ev_start),
  .ev_addr_done    (ev_addr_done),
  .ev_bit_mismatch (ev_bit_mismatch),
  .ev_irq_clr      (ev_irq_clr),
  .cpu_rd          (cpu_rd),
  .cpu_wr          (cpu_wr),
  .wd_arb          (cpu_wdata[i2c_stat_pkg::ARB_BIT]),
  .flag_xfer_cont  (flag_xfer_cont),
  .flag_addr2_hit  (flag_addr2_hit),
  .flag_arb_lost   (flag_arb_lost),
  .rd_xfer         (cpu_rdata[i2c_stat_pkg::XFER_BIT]),
  .rd_addr2        (cpu_rdata[i2c_stat_pkg::ADDR2_BIT]),
  .rd_arb          (cpu_rdata[i2c_stat_pkg::ARB_BIT])
);

// File: tb/tb_i2c_stat_flags.sv
`timescale 1ns/1ps
module tb_i2c_stat_flags;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_master = 0, mode_xmit = 0, mode_i2c_fmt = 1, alt_addr_off = 0;
  logic [6:0] alt_addr = 7'h5A;
  logic [7:0] rx_byte = 8'h00;
  logic       ev_tx_empty = 0, ev_rx_full = 0, ev_start = 0, ev_addr_done = 0;
  logic       ev_bit_mismatch = 0, ev_irq_clr = 0, cpu_rd = 0, cpu_wr = 0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       flag_xfer_cont, flag_addr2_hit, flag_arb_lost;

  int vectors = 0;
  int fails = 0;

  // reference model state
  bit       m_x, m_a, m_l, s_x, s_a, s_l;
  bit [7:0] m_rd;

  always #5 clk = ~clk;

  i2c_stat_flags dut (
    .clk(clk), .rst(rst), .mode_master(mode_master), .mode_xmit(mode_xmit),
    .mode_i2c_fmt(mode_i2c_fmt), .alt_addr_off(alt_addr_off), .alt_addr(alt_addr),
    .rx_byte(rx_byte), .ev_tx_empty(ev_tx_empty), .ev_rx_full(ev_rx_full),
    .ev_start(ev_start), .ev_addr_done(ev_addr_done), .ev_bit_mismatch(ev_bit_mismatch),
    .ev_irq_clr(ev_irq_clr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .flag_xfer_cont(flag_xfer_cont),
    .flag_addr2_hit(flag_addr2_hit), .flag_arb_lost(flag_arb_lost)
  );

  task automatic model_step();
    bit ga, ca, na, gx, cx, nx, gl, cl, nl;
    bit [7:0] snap;
    if (rst) begin
      m_x = 0; m_a = 0; m_l = 0; s_x = 0; s_a = 0; s_l = 0; m_rd = 8'h00;
    end else begin
      snap = {2'b00, m_x, m_a, m_l, 3'b000};
      // alternate address: slave, receive, bus format, enabled, rx_byte[7:1] match
      ga = ev_addr_done && !mode_master && !mode_xmit && mode_i2c_fmt && !alt_addr_off
           && (rx_byte[7:1] == alt_addr);
      ca = ev_start || mode_master || (cpu_wr && !cpu_wdata[4] && s_a);
      gx = (ev_tx_empty || ev_rx_full) && (mode_master || !mode_i2c_fmt || m_a);
      cx = ev_irq_clr || (cpu_wr && !cpu_wdata[5] && s_x);
      gl = mode_master && ev_bit_mismatch;
      cl = cpu_wr && !cpu_wdata[3] && s_l;
      na = ga || (m_a && !ca);
      nx = gx || (m_x && !cx);
      nl = gl || (m_l && !cl);
      s_a = (ca || !na) ? 1'b0 : (s_a || (cpu_rd && m_a));
      s_x = (cx || !nx) ? 1'b0 : (s_x || (cpu_rd && m_x));
      s_l = (cl || !nl) ? 1'b0 : (s_l || (cpu_rd && m_l));
      if (cpu_rd) m_rd = snap;
      m_a = na; m_x = nx; m_l = nl;
    end
  endtask

  task automatic compare(input string tag);
    vectors++;
    if (flag_xfer_cont !== m_x || flag_addr2_hit !== m_a || flag_arb_lost !== m_l
        || cpu_rdata !== m_rd) begin
      fails++;
      $display("FAIL %s: got xfer=%b addr2=%b arb=%b rdata=%h, expected xfer=%b addr2=%b arb=%b rdata=%h",
               tag, flag_xfer_cont, flag_addr2_hit, flag_arb_lost, cpu_rdata,
               m_x, m_a, m_l, m_rd);
    end
  endtask

  task automatic run(input string tag);
    @(posedge clk); #1;
    model_step();
    compare(tag);
    ev_tx_empty = 0; ev_rx_full = 0; ev_start = 0; ev_addr_done = 0;
    ev_bit_mismatch = 0; ev_irq_clr = 0; cpu_rd = 0; cpu_wr = 0;
  endtask

  task automatic rd(input string tag);
    cpu_rd = 1; run(tag);
  endtask

  task automatic wr(input bit [7:0] d, input string tag);
    cpu_wr = 1; cpu_wdata = d; run(tag);
  endtask

  task automatic addr_frame(input bit [7:0] b, input string tag);
    rx_byte = b; ev_addr_done = 1; run(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1 reset
    rd("R1 read during reset"); run("R1"); run("R1");
    rst = 0;
    run("R1 idle after reset"); rd("R2 read zero status");

    // R3 alternate address recognition
    addr_frame({7'h5B, 1'b0}, "R3 mismatch address");
    alt_addr_off = 1; addr_frame({7'h5A, 1'b1}, "R3 disabled by alt_addr_off"); alt_addr_off = 0;
    mode_xmit = 1; addr_frame({7'h5A, 1'b0}, "R3 transmit mode no set"); mode_xmit = 0;
    mode_i2c_fmt = 0; addr_frame({7'h5A, 1'b0}, "R3 other format no set"); mode_i2c_fmt = 1;

    // R5 gate: slave bus mode without hit
    ev_tx_empty = 1; run("R5 slave no hit, no set");
    addr_frame({7'h5A, 1'b1}, "R3 match sets hit");
    ev_rx_full = 1; run("R5 slave with hit sets");
    rd("R2 read shows xfer and hit");
    ev_irq_clr = 1; run("R6 irq clear");
    // R10: set and irq clear together
    ev_irq_clr = 1; ev_tx_empty = 1; run("R10 set beats irq clear");
    ev_irq_clr = 1; run("R6 irq clear again");

    // R4 start clears hit, R10 start with matching frame
    ev_start = 1; run("R4 start clears hit");
    ev_start = 1; rx_byte = {7'h5A, 1'b0}; ev_addr_done = 1; run("R10 hit beats start");
    mode_master = 1; run("R4 master clears hit"); mode_master = 0;

    // R7 arbitration
    ev_bit_mismatch = 1; run("R7 slave mismatch ignored");
    mode_master = 1; ev_bit_mismatch = 1; run("R7 master mismatch sets");
    wr(8'h00, "R8 write 0 without read keeps");
    wr(8'hFF, "R9 write 1 keeps");
    rd("R2 read arb lost");
    wr(8'hFF, "R9 armed write 1 keeps");
    cpu_wr = 1; cpu_wdata = 8'h00; ev_bit_mismatch = 1; run("R10 set beats armed write 0");
    wr(8'h00, "R11 arm lost after overridden clear");
    rd("R8 re-read arms");
    wr(8'h00, "R8 armed write 0 clears");
    ev_tx_empty = 1; run("R5 master sets xfer unconditionally");
    rd("R2 read xfer"); wr(8'hDF & 8'hFF, "R8 clear xfer");
    wr(8'h00, "R8 clear xfer bit 0");
    mode_master = 0;

    // R11 on hit flag: read, hw clear, re-set, write 0 must not clear
    addr_frame({7'h5A, 1'b0}, "R3 set hit");
    rd("R11 arm hit");
    ev_start = 1; run("R11 start disarms");
    addr_frame({7'h5A, 1'b1}, "R11 hit again");
    wr(8'h00, "R11 write 0 after disarm keeps");
    rd("R11 read re-arms");
    wr(8'h00, "R8 write 0 clears hit");
    mode_i2c_fmt = 0; ev_rx_full = 1; run("R5 other format sets xfer"); mode_i2c_fmt = 1;

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(15) == 0) mode_master = $urandom_range(1);
      if ($urandom_range(15) == 0) mode_xmit = $urandom_range(1);
      if ($urandom_range(31) == 0) mode_i2c_fmt = $urandom_range(1);
      if ($urandom_range(31) == 0) alt_addr_off = $urandom_range(1);
      rx_byte = $urandom_range(1) ? {alt_addr, 1'($urandom_range(1))} : 8'($urandom);
      ev_tx_empty = ($urandom_range(5) == 0);
      ev_rx_full = ($urandom_range(5) == 0);
      ev_start = ($urandom_range(7) == 0);
      ev_addr_done = ($urandom_range(3) == 0);
      ev_bit_mismatch = ($urandom_range(7) == 0);
      ev_irq_clr = ($urandom_range(5) == 0);
      cpu_rd = ($urandom_range(2) == 0);
      cpu_wr = ($urandom_range(2) == 0);
      cpu_wdata = 8'($urandom);
      run("R10 random mix");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule